// File: doc/BRIEF.md
# Supply Power-Good Supervisor with Overvoltage Fault Latch

This block watches a regulated supply through two digital comparator flags. One flag says the output sits inside a narrow band of about ±3% around the nominal voltage. The other says it has risen past 113% of nominal. From these flags the block produces a filtered power-good signal. Power-good drops only after a sustained excursion and comes back only after a longer stable period, so short noise spikes never reach the processor it signals.

Overvoltage protection is armed only while power-good is low. A detected overvoltage in that state immediately raises the fault output and pulls both gate-drive enables low, with no filtering. The fault then holds until the supply is recycled or the output-enable pin goes low and returns high. All three asynchronous inputs pass through two-flop synchronizers. The two filter delays are given in microseconds and converted to cycle counts from the clock-frequency parameter.

Top module: `pgood_supervisor`

## Requirements
- R1: Each of `in_window_i`, `over_volt_i` and `out_en_i` passes two flops before use. A change driven ahead of clock edge k is first acted on at edge k+2.
- R2: With enable high, `pwr_good_o` falls at the edge that evaluates the FALL-th consecutive synchronized out-of-window sample. Any shorter low run has no effect and restarts the count.
- R3: With enable high, `pwr_good_o` rises at the edge that evaluates the RISE-th consecutive synchronized in-window sample. Any shorter in-window run has no effect and restarts the count.
- R4: While `supply_rst` is high, `pwr_good_o`, `fault_o`, `gate_hi_en_o` and `gate_lo_en_o` are all 0.
- R5: An overvoltage flag seen while `pwr_good_o` is 1 leaves `fault_o` at 0 and the gate enables at 1.
- R6: With enable high and `pwr_good_o` at 0, a synchronized overvoltage flag sets `fault_o` to 1 and both gate enables to 0 in that same cycle. This includes the first cycle after power-good falls.
- R7: Once set, `fault_o` stays 1 and the gate enables stay 0 after the overvoltage flag clears and after power-good recovers.
- R8: While the synchronized enable is 0, `fault_o` and both gate enables are 0, and `pwr_good_o` is 0 from the next edge on. After enable returns high, power-good needs a full RISE period again.
- R9: A `supply_rst` pulse clears a latched fault.
- R10: FALL = CLK_HZ·FALL_US/10^6 and RISE = CLK_HZ·RISE_US/10^6 cycles, each at least 1. The defaults are 500 µs and 1000 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_rst | input | 1 | Synchronous active-high supply-recycle reset |
| in_window_i | input | 1 | Comparator flag: output within ±3% of nominal (async) |
| over_volt_i | input | 1 | Comparator flag: output above 113% of nominal (async) |
| out_en_i | input | 1 | Output enable; a low phase clears fault and power-good (async) |
| pwr_good_o | output | 1 | Filtered power-good |
| fault_o | output | 1 | Latched overvoltage fault |
| gate_hi_en_o | output | 1 | High-side gate-drive enable |
| gate_lo_en_o | output | 1 | Low-side gate-drive enable |

## Verification
Two events can land in the same cycle. Power-good can expire while an overvoltage is already present, and enable can fall while an overvoltage is armed. The bench raises the overvoltage flag together with the window-loss flag, then checks the cycle before and the cycle of the power-good fall: the fault must appear exactly as power-good reaches 0, never one cycle early while power-good is still 1. It also holds enable low with overvoltage active, and requires fault and gates to stay low throughout, because enable takes priority. Filter lengths are swept one cycle at a time on both sides of each threshold.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef struct packed {
        logic en;
        logic ov;
        logic win;
    } flags_t;

    function automatic int unsigned us_to_cycles(longint unsigned hz, int unsigned us);
        longint unsigned c;
        c = (hz * longint'(us)) / 64'd1_000_000;
        return (c == 0) ? 32'd1 : 32'(c);
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/pgs_debounce.sv
module pgs_debounce #(
    parameter int unsigned FALL_CYC = 5,
    parameter int unsigned RISE_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en_s,
    input  logic win_s,
    output logic pg_o
);
    localparam int unsigned MAXC = (FALL_CYC > RISE_CYC) ? FALL_CYC : RISE_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FALL_LIM = CW'(FALL_CYC - 1);
    localparam logic [CW-1:0] RISE_LIM = CW'(RISE_CYC - 1);

    typedef struct packed {
        logic          pg;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = st_q.pg ? FALL_LIM : RISE_LIM;
        if (!en_s) begin
            st_d = '0;
        end else if (win_s == st_q.pg) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == limit) begin
            st_d.pg  = ~st_q.pg;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pg_o = st_q.pg;
endmodule

// File: rtl/pgs_fault.sv
module pgs_fault (
    input  logic clk,
    input  logic rst,
    input  logic en_s,
    input  logic pg_q,
    input  logic ov_s,
    output logic fault_o,
    output logic gate_en_o
);
    typedef struct packed {
        logic latched;
    } st_t;

    st_t  st_d, st_q;
    logic trip;

    always_comb begin
        trip = en_s & ~pg_q & ov_s;
        st_d = st_q;
        if (!en_s)     st_d.latched = 1'b0;
        else if (trip) st_d.latched = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fault_o   = en_s & (st_q.latched | trip);
    assign gate_en_o = en_s & ~fault_o;
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor #(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned     FALL_US = 500,
    parameter int unsigned     RISE_US = 1000
) (
    input  logic clk,
    input  logic supply_rst,
    input  logic in_window_i,
    input  logic over_volt_i,
    input  logic out_en_i,
    output logic pwr_good_o,
    output logic fault_o,
    output logic gate_hi_en_o,
    output logic gate_lo_en_o
);
    import pgs_pkg::*;

    localparam int unsigned FALL_CYC = us_to_cycles(CLK_HZ, FALL_US);
    localparam int unsigned RISE_CYC = us_to_cycles(CLK_HZ, RISE_US);
    localparam int unsigned NFLAGS   = $bits(flags_t);
    localparam int unsigned NGATES   = 2;

    flags_t raw, synced;
    logic   win_s, ov_s, en_s;
    logic   pg_q, gate_en;
    logic [NGATES-1:0] gates;

    always_comb begin
        raw     = '0;
        raw.win = in_window_i;
        raw.ov  = over_volt_i;
        raw.en  = out_en_i;
    end

    pgs_sync #(.W(NFLAGS)) u_sync (
        .clk     (clk),
        .rst     (supply_rst),
        .async_i (raw),
        .sync_o  (synced)
    );

    assign win_s = synced.win;
    assign ov_s  = synced.ov;
    assign en_s  = synced.en;

    pgs_debounce #(.FALL_CYC(FALL_CYC), .RISE_CYC(RISE_CYC)) u_deb (
        .clk   (clk),
        .rst   (supply_rst),
        .en_s  (en_s),
        .win_s (win_s),
        .pg_o  (pg_q)
    );

    pgs_fault u_flt (
        .clk       (clk),
        .rst       (supply_rst),
        .en_s      (en_s),
        .pg_q      (pg_q),
        .ov_s      (ov_s),
        .fault_o   (fault_o),
        .gate_en_o (gate_en)
    );

    for (genvar g = 0; g < NGATES; g++) begin : g_gate
        assign gates[g] = gate_en;
    end

    assign pwr_good_o   = pg_q;
    assign gate_hi_en_o = gates[0];
    assign gate_lo_en_o = gates[1];
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
    parameter int unsigned FALL_CYC = 5
) (
    input logic clk,
    input logic supply_rst,
    input logic win_s,
    input logic ov_s,
    input logic en_s,
    input logic pwr_good_o,
    input logic fault_o,
    input logic gate_hi_en_o,
    input logic gate_lo_en_o
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (supply_rst || win_s || !en_s) low_run <= 0;
        else if (low_run < FALL_CYC + 4)  low_run <= low_run + 1;
    end

    p_fall_after_full_run_r2: assert property (@(posedge clk) disable iff (supply_rst)
        ($fell(pwr_good_o) && $past(en_s)) |-> (low_run >= FALL_CYC));

    p_rise_needs_window_r3: assert property (@(posedge clk) disable iff (supply_rst)
        $rose(pwr_good_o) |-> ($past(win_s) && $past(en_s)));

    p_no_fault_while_good_r5: assert property (@(posedge clk) disable iff (supply_rst)
        $rose(fault_o) |-> !pwr_good_o);

    p_trip_drops_gates_r6: assert property (@(posedge clk) disable iff (supply_rst)
        (en_s && !pwr_good_o && ov_s) |-> (fault_o && !gate_hi_en_o && !gate_lo_en_o));

    p_fault_holds_r7: assert property (@(posedge clk) disable iff (supply_rst)
        (fault_o && en_s) |=> (fault_o || !en_s));

    p_enable_low_clears_r8: assert property (@(posedge clk) disable iff (supply_rst)
        !en_s |-> (!fault_o && !gate_hi_en_o && !gate_lo_en_o));

    p_fault_gates_r6: assert property (@(posedge clk) disable iff (supply_rst)
        fault_o |-> (!gate_hi_en_o && !gate_lo_en_o));

    always_comb begin
        if (supply_rst && $realtime > 0) begin
            a_reset_quiet_r4: assert (!gate_hi_en_o && !gate_lo_en_o);
        end
    end
endmodule

bind pgood_supervisor pgs_checker #(.FALL_CYC(FALL_CYC)) u_chk (
    .clk          (clk),
    .supply_rst   (supply_rst),
    .win_s        (win_s),
    .ov_s         (ov_s),
    .en_s         (en_s),
    .pwr_good_o   (pwr_good_o),
    .fault_o      (fault_o),
    .gate_hi_en_o (gate_hi_en_o),
    .gate_lo_en_o (gate_lo_en_o)
);

// File: tb/test_pgood_supervisor.sv
module test_pgood_supervisor;
    localparam longint unsigned CLK_HZ = 10_000;
    // R10: delays derived from the clock parameter, computed here independently
    localparam int FALL = int'(CLK_HZ * 500 / 1_000_000);
    localparam int RISE = int'(CLK_HZ * 1000 / 1_000_000);

    logic clk = 1'b0;
    logic supply_rst = 1'b1;
    logic win = 1'b1, ov = 1'b0, en = 1'b1;
    logic pg, flt, ghi, glo;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pgood_supervisor #(.CLK_HZ(CLK_HZ)) i_pgood_supervisor (
        .clk(clk), .supply_rst(supply_rst), .in_window_i(win),
        .over_volt_i(ov), .out_en_i(en), .pwr_good_o(pg),
        .fault_o(flt), .gate_hi_en_o(ghi), .gate_lo_en_o(glo)
    );

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_gates(string req, logic exp);
        chk(req, ghi, exp);
        chk(req, glo, exp);
    endtask

    initial begin
        edges(3);
        chk("R4 pg in reset", pg, 1'b0);
        chk("R4 fault in reset", flt, 1'b0);
        chk_gates("R4 gates in reset", 1'b0);
        supply_rst = 1'b0;
        // R1 + R3: in window from release, pg rises at edge RISE+2
        edges(RISE + 1);
        chk("R1 R3 pg one edge early", pg, 1'b0);
        edges(1);
        chk("R1 R3 pg exact rise", pg, 1'b1);
        chk_gates("R8 gates enabled", 1'b1);

        // R2 sweep of out-of-window run length
        for (int l = 1; l <= FALL + 2; l++) begin
            win = 1'b0; edges(l);
            win = 1'b1; edges(3);
            chk($sformatf("R2 R10 run %0d", l), pg, (l < FALL) ? 1'b1 : 1'b0);
            edges(RISE + 6);
            chk("R3 recovered", pg, 1'b1);
        end

        // R3 sweep of in-window run length
        win = 1'b0; edges(FALL + 4);
        chk("R2 pg low", pg, 1'b0);
        for (int l = 1; l <= RISE + 2; l++) begin
            win = 1'b1; edges(l);
            win = 1'b0; edges(3);
            chk($sformatf("R3 R10 run %0d", l), pg, (l < RISE) ? 1'b0 : 1'b1);
            edges(FALL + 4);
        end
        win = 1'b1; edges(RISE + 4);
        chk("R3 pg back", pg, 1'b1);

        // R5: overvoltage while good is ignored
        ov = 1'b1;
        for (int i = 0; i < 6; i++) begin
            edges(3);
            chk("R5 fault ignored", flt, 1'b0);
            chk_gates("R5 gates stay", 1'b1);
        end
        ov = 1'b0; edges(3);

        // R6: window loss and overvoltage together
        win = 1'b0; ov = 1'b1;
        edges(FALL + 1);
        chk("R6 pg before fall", pg, 1'b1);
        chk("R5 R6 no early fault", flt, 1'b0);
        chk_gates("R6 gates before fall", 1'b1);
        edges(1);
        chk("R6 pg fell", pg, 1'b0);
        chk("R6 fault same cycle", flt, 1'b1);
        chk_gates("R6 gates dropped", 1'b0);

        // R7: latch holds
        ov = 1'b0; win = 1'b1;
        edges(RISE + 8);
        chk("R7 pg recovered", pg, 1'b1);
        chk("R7 fault held", flt, 1'b1);
        chk_gates("R7 gates held low", 1'b0);

        // R8: enable toggle with overvoltage held
        en = 1'b0; ov = 1'b1;
        edges(1);
        chk("R1 R8 fault before en sync", flt, 1'b1);
        edges(1);
        chk("R8 fault cleared", flt, 1'b0);
        chk_gates("R8 gates low", 1'b0);
        edges(1);
        chk("R8 pg cleared", pg, 1'b0);
        for (int i = 0; i < 4; i++) begin
            edges(1);
            chk("R8 en low beats ov", flt, 1'b0);
            chk_gates("R8 gates low with ov", 1'b0);
        end
        ov = 1'b0; en = 1'b1;
        edges(2);
        chk_gates("R8 gates back", 1'b1);
        edges(RISE - 1);
        chk("R8 pg still low", pg, 1'b0);
        edges(1);
        chk("R8 pg full recovery", pg, 1'b1);
        chk("R8 fault clear", flt, 1'b0);

        // R9: supply recycle clears fault
        win = 1'b0; edges(FALL + 4);
        ov = 1'b1; edges(1);
        chk("R1 fault waits sync", flt, 1'b0);
        edges(1);
        chk("R6 fault while low", flt, 1'b1);
        supply_rst = 1'b1; edges(2);
        chk("R9 fault cleared", flt, 1'b0);
        chk("R4 pg cleared", pg, 1'b0);
        chk_gates("R4 gates in reset", 1'b0);
        ov = 1'b0; win = 1'b1; supply_rst = 1'b0;
        edges(RISE + 4);
        chk("R9 pg after recycle", pg, 1'b1);
        chk("R9 no fault after recycle", flt, 1'b0);
        chk_gates("R9 gates after recycle", 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule